// File: doc/BRIEF.md
# Burst Beat Address Generator

This block turns one burst request into a stream of per-beat addresses for a memory-mapped bus. A request carries a start address, a two-bit burst type code, a length field and a size field. Once accepted, the block emits one address per output handshake and raises a last-beat flag on the final beat, so a downstream data mover can pace itself purely from the beat stream.

Three address patterns are supported: a constant address (suited to FIFO-style targets), a linear walk in steps of the beat size, and a wrapping walk that stays inside a window. The window size is the beat size times the beat count, and it is aligned to its own size. Only one burst is handled at a time. The request port is closed while a burst is running.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and whenever reset is asserted during a burst, `req_ready` is 1, `beat_valid` is 0 and `beat_last` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. The first beat appears in the next cycle with `beat_addr` equal to `req_addr`. `req_ready` stays 0 while a burst is in progress. It returns to 1 in the cycle after the last beat's handshake.
- R3: With `req_kind` = 2'b00 (fixed), every beat carries the start address unchanged.
- R4: With `req_kind` = 2'b01 (linear), each beat after the first is the previous address rounded down to a multiple of 2^`req_size`, plus 2^`req_size`.
- R5: With `req_kind` = 2'b10 and `req_len` equal to 1, 3, 7 or 15, the window is W = 2^`req_size` × (`req_len`+1). Its base is the start address rounded down to a multiple of W. Addresses step as in R4, and an address that would reach base+W is replaced by the base.
- R6: With `req_kind` = 2'b10 and any other `req_len`, the burst behaves exactly as a linear burst (R4).
- R7: `req_kind` = 2'b11 behaves exactly as a linear burst (R4).
- R8: A burst has `req_len`+1 beats. `beat_last` is 1 on the final beat only.
- R9: A beat advances only in a cycle with `beat_valid` and `beat_ready` both 1. While `beat_ready` is 0, `beat_addr` and `beat_last` hold.
- R10: `req_valid` and request fields presented during a burst have no effect on the beats of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | ADDR_W | Start address |
| req_kind | input | 2 | Burst type: 00 fixed, 01 linear, 10 wrapping, 11 linear |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | Beat size is 2^req_size bytes |
| beat_valid | output | 1 | Beat address valid |
| beat_ready | input | 1 | Receiver takes the beat |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The wrap fold and the last-beat flag can land on the same beat. This happens in a wrapping burst that starts one beat above its window base: the final beat is then the folded base address. The bench runs such a burst and checks that the final beat both carries the base address and has `beat_last` set. It also runs a burst starting at the top of a window, where the fold happens mid-burst instead. A stall of the output handshake is placed on a middle beat to confirm that neither the address nor the last flag moves while the receiver holds off.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    localparam int LG_W   = 3;

    typedef enum logic [1:0] {
        BK_FIXED = 2'b00,
        BK_INCR  = 2'b01,
        BK_WRAP  = 2'b10,
        BK_ALT   = 2'b11
    } burst_kind_e;

    typedef struct packed {
        burst_kind_e        kind;
        logic [LEN_W-1:0]   left;
    } burst_cfg_t;

    // log2 of the beat count for lengths that may wrap, zero otherwise
    function automatic logic [LG_W-1:0] wrap_lg(input logic [LEN_W-1:0] len);
        case (len)
            LEN_W'(1):  return LG_W'(1);
            LEN_W'(3):  return LG_W'(2);
            LEN_W'(7):  return LG_W'(3);
            LEN_W'(15): return LG_W'(4);
            default:    return LG_W'(0);
        endcase
    endfunction

    // map the raw code onto the three patterns actually generated
    function automatic burst_kind_e resolve_kind(input logic [1:0] code,
                                                 input logic [LEN_W-1:0] len);
        case (code)
            2'b00:   return BK_FIXED;
            2'b10:   return (wrap_lg(len) != '0) ? BK_WRAP : BK_INCR;
            default: return BK_INCR;
        endcase
    endfunction

endpackage

// File: rtl/bag_mask.sv
module bag_mask
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [LG_W-1:0]   lg,
    output logic [ADDR_W-1:0] step,
    output logic [ADDR_W-1:0] wmask
);
    always_comb begin
        step  = ADDR_W'(1) << size;
        wmask = (step << lg) - ADDR_W'(1);
    end
endmodule

// File: rtl/bag_step.sv
module bag_step
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  burst_kind_e       kind,
    input  logic [ADDR_W-1:0] step,
    input  logic [ADDR_W-1:0] wmask,
    output logic [ADDR_W-1:0] next
);
    logic [ADDR_W-1:0] lin;

    always_comb begin
        lin = (cur & ~(step - ADDR_W'(1))) + step;
        case (kind)
            BK_FIXED: next = cur;
            BK_WRAP:  next = (cur & ~wmask) | (lin & wmask);
            default:  next = lin;
        endcase
    end
endmodule

// File: rtl/bag_ctrl.sv
module bag_ctrl
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  burst_cfg_t        req_cfg,
    input  logic [ADDR_W-1:0] req_step,
    input  logic [ADDR_W-1:0] req_mask,
    input  logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output burst_kind_e       cur_kind,
    output logic [ADDR_W-1:0] cur_step,
    output logic [ADDR_W-1:0] cur_mask,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic              beat_last
);
    logic       active;
    burst_cfg_t cfg_q;
    logic       take;
    logic       fire;

    assign req_ready  = !active;
    assign take       = req_valid && !active;
    assign fire       = active && beat_ready;
    assign beat_valid = active;
    assign beat_last  = active && (cfg_q.left == '0);
    assign cur_kind   = cfg_q.kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cur_addr <= '0;
            cfg_q    <= '{kind: BK_INCR, left: '0};
            cur_step <= '0;
            cur_mask <= '0;
        end else if (take) begin
            active   <= 1'b1;
            cur_addr <= req_addr;
            cfg_q    <= req_cfg;
            cur_step <= req_step;
            cur_mask <= req_mask;
        end else if (fire) begin
            if (cfg_q.left == '0) begin
                active <= 1'b0;
            end else begin
                cur_addr   <= next_addr;
                cfg_q.left <= cfg_q.left - LEN_W'(1);
            end
        end
    end

    // R2
    ready_closed_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);

    // R2
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && beat_last |=> req_ready && !beat_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(cur_addr) && $stable(beat_last));

    // R8
    single_last_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_cfg.left == '0) |=> beat_last);

    // R3
    fixed_addr_chk: assert property (@(posedge clk) disable iff (rst)
        fire && !beat_last && (cfg_q.kind == BK_FIXED) |=> $stable(cur_addr));

    // R5
    wrap_window_chk: assert property (@(posedge clk) disable iff (rst)
        fire && !beat_last && (cfg_q.kind == BK_WRAP)
        |=> ((cur_addr ^ $past(cur_addr)) & ~$past(cur_mask)) == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [7:0]        req_len,
    input  logic [2:0]        req_size,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last
);
    burst_cfg_t        req_cfg;
    logic [ADDR_W-1:0] req_step, req_mask;
    logic [ADDR_W-1:0] cur_step, cur_mask, next_addr;
    burst_kind_e       cur_kind;

    assign req_cfg = '{kind: resolve_kind(req_kind, req_len), left: req_len};

    bag_mask #(.ADDR_W(ADDR_W)) u_mask (
        .size  (req_size),
        .lg    (wrap_lg(req_len)),
        .step  (req_step),
        .wmask (req_mask)
    );

    bag_step #(.ADDR_W(ADDR_W)) u_step (
        .cur   (beat_addr),
        .kind  (cur_kind),
        .step  (cur_step),
        .wmask (cur_mask),
        .next  (next_addr)
    );

    bag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_cfg    (req_cfg),
        .req_step   (req_step),
        .req_mask   (req_mask),
        .next_addr  (next_addr),
        .cur_addr   (beat_addr),
        .cur_kind   (cur_kind),
        .cur_step   (cur_step),
        .cur_mask   (cur_mask),
        .beat_valid (beat_valid),
        .beat_ready (beat_ready),
        .beat_last  (beat_last)
    );
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic        beat_valid;
    logic        beat_ready = 1'b1;
    logic [31:0] beat_addr;
    logic        beat_last;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_len(req_len), .req_size(req_size),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [31:0] last_addr;
        logic        stall;
        logic        junk;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1004, 2'b00, 8'd3,  3'd2, 32'h0000_1004, 1'b1, 1'b0},
        '{32'h0000_2000, 2'b01, 8'd3,  3'd2, 32'h0000_200C, 1'b0, 1'b1},
        '{32'h0000_3008, 2'b10, 8'd3,  3'd2, 32'h0000_3004, 1'b1, 1'b0},
        '{32'h0000_3004, 2'b10, 8'd3,  3'd2, 32'h0000_3000, 1'b0, 1'b0},
        '{32'h0000_4008, 2'b10, 8'd2,  3'd2, 32'h0000_4010, 1'b0, 1'b0},
        '{32'h0000_5000, 2'b11, 8'd1,  3'd3, 32'h0000_5008, 1'b0, 1'b0},
        '{32'h0000_6003, 2'b01, 8'd2,  3'd2, 32'h0000_6008, 1'b1, 1'b0},
        '{32'h0000_007E, 2'b10, 8'd15, 3'd0, 32'h0000_007D, 1'b0, 1'b1},
        '{32'h0000_8000, 2'b01, 8'd0,  3'd2, 32'h0000_8000, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] kind, input logic [7:0] len);
        if (kind == 2'b00) return "R3";
        if (kind == 2'b11) return "R7";
        if (kind == 2'b10) begin
            if (len == 1 || len == 3 || len == 7 || len == 15) return "R5";
            return "R6";
        end
        return "R4";
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] a, input logic [1:0] kind,
                                               input logic [7:0] len, input logic [2:0] size);
        logic [31:0] b, win, base, n;
        b = 32'd1 << size;
        if (kind == 2'b00) return a;
        n = a - (a % b) + b;
        if (kind == 2'b10 && (len == 1 || len == 3 || len == 7 || len == 15)) begin
            win  = b * (32'(len) + 1);
            base = a - (a % win);
            if (n >= base + win) n = base;
        end
        return n;
    endfunction

    task automatic run(input vec_t v);
        logic [31:0] exp;
        int n;
        string tg;
        tg  = tag_of(v.kind, v.len);
        exp = v.addr;
        n   = int'(v.len) + 1;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 idle ready", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = v.addr; req_kind = v.kind;
        req_len = v.len; req_size = v.size;
        @(negedge clk);
        if (v.junk) begin
            // R10: keep offering a different request during the burst
            req_addr = 32'hDEAD_0000; req_kind = 2'b00; req_len = 8'd0; req_size = 3'd0;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            check(beat_valid == 1'b1, "R2 beat valid", 32'(beat_valid), 32'd1);
            check(req_ready == 1'b0, "R2 ready closed", 32'(req_ready), 32'd0);
            check(beat_addr == exp, v.junk ? "R10 addr" : tg, beat_addr, exp);
            check(beat_last == (i == n - 1), "R8 last flag", 32'(beat_last), 32'(i == n - 1));
            if (i == n - 1)
                check(beat_addr == v.last_addr, {tg, " final addr"}, beat_addr, v.last_addr);
            if (v.stall && i == 1) begin
                beat_ready = 1'b0;
                @(negedge clk);
                check(beat_valid && beat_addr == exp, "R9 stall addr", beat_addr, exp);
                check(beat_last == (i == n - 1), "R9 stall last", 32'(beat_last), 32'(i == n - 1));
                beat_ready = 1'b1;
            end
            if (i == n - 1) req_valid = 1'b0;
            @(negedge clk);
            exp = model_next(exp, v.kind, v.len, v.size);
        end
        check(req_ready == 1'b1, "R2 reopen", 32'(req_ready), 32'd1);
        check(beat_valid == 1'b0, "R8 no extra beat", 32'(beat_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(beat_valid == 1'b0, "R1 reset valid", 32'(beat_valid), 32'd0);
        check(beat_last == 1'b0, "R1 reset last", 32'(beat_last), 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) run(VECS[k]);

        // R1: reset in the middle of a burst returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000; req_kind = 2'b01; req_len = 8'd5; req_size = 3'd2;
        @(negedge clk);
        req_valid = 1'b0; beat_ready = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 mid reset ready", 32'(req_ready), 32'd1);
        check(beat_valid == 1'b0, "R1 mid reset valid", 32'(beat_valid), 32'd0);
        check(beat_last == 1'b0, "R1 mid reset last", 32'(beat_last), 32'd0);
        rst = 1'b0; beat_ready = 1'b1;

        // R6: wrap code with 6 beats runs linearly past the would-be window
        run('{32'h0000_A010, 2'b10, 8'd5, 3'd2, 32'h0000_A024, 1'b0, 1'b0});

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule